// File: doc/BRIEF.md
# Two-Way Set-Associative Read Cache

This block is a read-only cache array with two ways per set and one recency bit per set, sized to sit in front of an instruction fetch path. A read request presents a byte address. The set index picks one set. Both ways of that set check their valid bit and compare their stored tag with the request tag at the same time. The two match lines are ORed to form the hit. A two-input multiplexer, steered by the way that matched, returns the addressed 32-bit word of that way's line in the same cycle.

On a miss the block stalls the requester and asks a memory port for the whole line. When the line arrives it goes into a victim way. An empty way is used first. If both ways are valid, the way that the set's recency bit names as least recently used is replaced. Each hit and each refill moves the recency bit to point at the other way. The requester keeps its request up while stalled and gets a hit on the cycle after the line arrives.

The geometry is 1 KB of storage in 32-byte lines, which gives 16 sets, two ways and a 23-bit tag.

Top module: `assoc2_icache`

## Requirements
- R1: The address splits as follows. Bits [4:2] pick the 32-bit word within the line, and bits [1:0] are ignored. Bits [8:5] are the set index, and bits [31:9] are the tag.
- R2: `cpu_hit` is high in the same cycle as the request when either way of the indexed set is valid and holds the request tag. It is never high while a refill is in progress.
- R3: On a hit, `cpu_data` is the word that R1 selects from the line of the matching way.
- R4: A request that misses raises `cpu_stall` in the same cycle. From the next cycle `mem_req` is high, with `mem_addr` set to the request address with bits [4:0] cleared. Both hold steady until a cycle with `mem_valid` high.
- R5: On the cycle after `mem_valid` delivers a line, a repeated request to that line hits and returns the data just delivered. `mem_line` bits [32k+31:32k] carry word k.
- R6: A refill into a set with an invalid way goes into that way, checking way 0 first. Two lines with the same index can therefore be resident together.
- R7: When both ways are valid, a refill replaces the least recently used way. A hit makes the other way of that set the least recently used, and so does a refill.
- R8: Reset invalidates every line. After reset `cpu_hit`, `cpu_stall` and `mem_req` are low, and the first request to any address misses.
- R9: At most one way of a set matches a given tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Read request, held while stalled |
| cpu_addr | input | 32 | Byte address of the request |
| cpu_data | output | 32 | Word read on a hit |
| cpu_hit | output | 1 | Request hit this cycle |
| cpu_stall | output | 1 | Request cannot complete this cycle |
| mem_req | output | 1 | Line fetch outstanding |
| mem_addr | output | 32 | Line-aligned fetch address |
| mem_valid | input | 1 | Fetched line present on `mem_line` |
| mem_line | input | 256 | Fetched line, word 0 in the low bits |

## Verification
Some internal faults show up as hits or misses that do not match a reference model of tags, valid bits and recency bits. These include a wrong recency bit, a victim taken from the wrong way, and a valid bit that is lost or set wrongly. Such a fault shows at `cpu_hit` only on the next request that maps to the damaged set. That can be many requests later, so the stimulus reuses a small pool of tags on few sets to make conflicts frequent. Faults in the data path show at once, as a wrong `cpu_data` on the hit that follows each refill. Faults in the fill address also show at once, as a wrong `mem_addr` one cycle after the miss.

// File: rtl/ica_pkg.sv
package ica_pkg;
    localparam int ADDR_W     = 32;
    localparam int WORD_W     = 32;
    localparam int LINE_BYTES = 32;
    localparam int SETS       = 16;
    localparam int WAYS       = 2;

    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
    localparam int LINE_W = LINE_BYTES * 8;
    localparam int WORDS  = LINE_W / WORD_W;
    localparam int WSEL_W = $clog2(WORDS);
    localparam int BSEL_W = OFF_W - WSEL_W;

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [WSEL_W-1:0] wsel_t;
    typedef logic [LINE_W-1:0] line_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        tag_t  tag;
        idx_t  idx;
        wsel_t wsel;
    } req_fields_t;

    typedef enum logic {ST_LOOKUP, ST_FILL} fill_st_e;

    function automatic req_fields_t split_addr(input logic [ADDR_W-1:0] a);
        req_fields_t f;
        f.tag  = a[ADDR_W-1 -: TAG_W];
        f.idx  = a[OFF_W +: IDX_W];
        f.wsel = a[BSEL_W +: WSEL_W];
        return f;
    endfunction

    function automatic word_t pick_word(input line_t l, input wsel_t s);
        return l[s*WORD_W +: WORD_W];
    endfunction
endpackage

// File: rtl/ica_way.sv
module ica_way
    import ica_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  idx_t  rd_idx,
    input  tag_t  rd_tag,
    output logic  valid_o,
    output logic  match_o,
    output line_t line_o,
    input  logic  wr_en,
    input  idx_t  wr_idx,
    input  tag_t  wr_tag,
    input  line_t wr_line
);
    logic [SETS-1:0] vld_q;
    tag_t            tag_q  [SETS];
    line_t           data_q [SETS];

    always_ff @(posedge clk) begin
        if (rst)        vld_q <= '0;
        else if (wr_en) vld_q[wr_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]  <= wr_tag;
            data_q[wr_idx] <= wr_line;
        end
    end

    always_comb begin
        valid_o = vld_q[rd_idx];
        match_o = vld_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
        line_o  = data_q[rd_idx];
    end
endmodule

// File: rtl/ica_lru.sv
module ica_lru
    import ica_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            touch_en,
    input  idx_t            touch_idx,
    input  logic            touch_way,
    output logic [SETS-1:0] lru_o
);
    logic [SETS-1:0] lru_q;

    always_ff @(posedge clk) begin
        if (rst)           lru_q <= '0;
        else if (touch_en) lru_q[touch_idx] <= ~touch_way;
    end

    assign lru_o = lru_q;
endmodule

// File: rtl/ica_fill_ctrl.sv
module ica_fill_ctrl
    import ica_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              miss,
    input  tag_t              miss_tag,
    input  idx_t              miss_idx,
    input  logic              victim,
    input  logic              mem_valid,
    output logic              in_fill,
    output logic              fill_done,
    output tag_t              fill_tag,
    output idx_t              fill_idx,
    output logic              fill_way,
    output logic [ADDR_W-1:0] mem_addr
);
    fill_st_e st_q;
    tag_t     tag_q;
    idx_t     idx_q;
    logic     way_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_LOOKUP;
        end else begin
            case (st_q)
                ST_LOOKUP: if (miss)      st_q <= ST_FILL;
                ST_FILL:   if (mem_valid) st_q <= ST_LOOKUP;
                default:                  st_q <= ST_LOOKUP;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (st_q == ST_LOOKUP && miss) begin
            tag_q <= miss_tag;
            idx_q <= miss_idx;
            way_q <= victim;
        end
    end

    always_comb begin
        in_fill   = (st_q == ST_FILL);
        fill_done = in_fill && mem_valid;
        fill_tag  = tag_q;
        fill_idx  = idx_q;
        fill_way  = way_q;
        mem_addr  = {tag_q, idx_q, {OFF_W{1'b0}}};
    end
endmodule

// File: rtl/assoc2_icache.sv
module assoc2_icache
    import ica_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         cpu_req,
    input  logic [31:0]  cpu_addr,
    output logic [31:0]  cpu_data,
    output logic         cpu_hit,
    output logic         cpu_stall,
    output logic         mem_req,
    output logic [31:0]  mem_addr,
    input  logic         mem_valid,
    input  logic [255:0] mem_line
);
    req_fields_t     req_f;
    idx_t            rd_idx;
    logic [WAYS-1:0] way_valid;
    logic [WAYS-1:0] way_match;
    line_t           way_line [WAYS];
    logic [SETS-1:0] lru_vec;
    logic            in_fill, fill_done, fill_way, victim, miss;
    tag_t            fill_tag;
    idx_t            fill_idx;
    logic            touch_en, touch_way;
    idx_t            touch_idx;
    line_t           sel_line;

    assign req_f  = split_addr(cpu_addr);
    assign rd_idx = req_f.idx;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        ica_way u_way (
            .clk     (clk),
            .rst     (rst),
            .rd_idx  (rd_idx),
            .rd_tag  (req_f.tag),
            .valid_o (way_valid[w]),
            .match_o (way_match[w]),
            .line_o  (way_line[w]),
            .wr_en   (fill_done && (fill_way == w[0])),
            .wr_idx  (fill_idx),
            .wr_tag  (fill_tag),
            .wr_line (mem_line)
        );
    end

    always_comb begin
        if (!way_valid[0])      victim = 1'b0;
        else if (!way_valid[1]) victim = 1'b1;
        else                    victim = lru_vec[rd_idx];
    end

    assign cpu_hit   = cpu_req && !in_fill && (|way_match);
    assign miss      = cpu_req && !in_fill && !(|way_match);
    assign cpu_stall = in_fill || miss;
    assign mem_req   = in_fill;
    assign sel_line  = way_match[1] ? way_line[1] : way_line[0];
    assign cpu_data  = pick_word(sel_line, req_f.wsel);

    always_comb begin
        touch_en  = cpu_hit || fill_done;
        touch_idx = fill_done ? fill_idx : rd_idx;
        touch_way = fill_done ? fill_way : way_match[1];
    end

    ica_lru u_lru (
        .clk       (clk),
        .rst       (rst),
        .touch_en  (touch_en),
        .touch_idx (touch_idx),
        .touch_way (touch_way),
        .lru_o     (lru_vec)
    );

    ica_fill_ctrl u_fill (
        .clk       (clk),
        .rst       (rst),
        .miss      (miss),
        .miss_tag  (req_f.tag),
        .miss_idx  (rd_idx),
        .victim    (victim),
        .mem_valid (mem_valid),
        .in_fill   (in_fill),
        .fill_done (fill_done),
        .fill_tag  (fill_tag),
        .fill_idx  (fill_idx),
        .fill_way  (fill_way),
        .mem_addr  (mem_addr)
    );
endmodule

// File: rtl/ica_chk.sv
module ica_chk
    import ica_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            cpu_req,
    input logic            cpu_hit,
    input logic            cpu_stall,
    input logic            mem_req,
    input logic            mem_valid,
    input logic [31:0]     mem_addr,
    input logic [WAYS-1:0] way_match,
    input idx_t            rd_idx,
    input logic [SETS-1:0] lru_vec
);
    // R4
    miss_stalls_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && !cpu_hit) |-> cpu_stall);

    // R2
    hit_not_stalled_chk: assert property (@(posedge clk) disable iff (rst)
        !(cpu_hit && cpu_stall));

    // R4
    fetch_held_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

    // R2
    fetch_blocks_hit_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (cpu_stall && !cpu_hit));

    // R9
    single_match_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(way_match));

    // R7
    lru_after_hit_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_hit |=> (lru_vec[$past(rd_idx)] == $past(way_match[0])));

    // R4
    line_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[OFF_W-1:0] == '0));
endmodule

bind assoc2_icache ica_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_req   (cpu_req),
    .cpu_hit   (cpu_hit),
    .cpu_stall (cpu_stall),
    .mem_req   (mem_req),
    .mem_valid (mem_valid),
    .mem_addr  (mem_addr),
    .way_match (way_match),
    .rd_idx    (rd_idx),
    .lru_vec   (lru_vec)
);

// File: tb/sim_assoc2_icache.sv
module sim_assoc2_icache;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cpu_req = 1'b0;
    logic [31:0]  cpu_addr = '0;
    logic [31:0]  cpu_data;
    logic         cpu_hit, cpu_stall, mem_req;
    logic [31:0]  mem_addr;
    logic         mem_valid = 1'b0;
    logic [255:0] mem_line = '0;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    logic        m_vld [16][2];
    logic [22:0] m_tag [16][2];
    logic        m_lru [16];

    always #2 clk = ~clk;

    assoc2_icache u0 (.*);

    function automatic logic [31:0] mem_word(input logic [31:0] la, input int w);
        return (la * 32'h9E37_79B1) ^ (w * 32'h0101_0101) ^ 32'h5A00_00A5;
    endfunction

    function automatic logic [255:0] mk_line(input logic [31:0] la);
        logic [255:0] l;
        for (int w = 0; w < 8; w++) l[w*32 +: 32] = mem_word(la, w);
        return l;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic access(input logic [31:0] a);
        logic [3:0]  idx;
        logic [22:0] tg;
        logic [31:0] la, expd;
        bit h0, h1, v;
        int lat;
        idx  = a[8:5];
        tg   = a[31:9];
        la   = {a[31:5], 5'b0};
        expd = mem_word(la, int'(a[4:2]));
        h0   = m_vld[idx][0] && m_tag[idx][0] == tg;
        h1   = m_vld[idx][1] && m_tag[idx][1] == tg;
        @(negedge clk);
        cpu_req  = 1'b1;
        cpu_addr = a;
        #1;
        check(cpu_hit == (h0 || h1), "R2/R7 hit", 32'(cpu_hit), 32'(h0 || h1));
        if (h0 || h1) begin
            check(cpu_data == expd, "R3 data", cpu_data, expd);
            m_lru[idx] = h0;
            @(posedge clk);
        end else begin
            check(cpu_stall == 1'b1, "R4 stall", 32'(cpu_stall), 32'd1);
            if (!m_vld[idx][0])      v = 1'b0;
            else if (!m_vld[idx][1]) v = 1'b1;
            else                     v = m_lru[idx];
            @(posedge clk);
            lat = $urandom_range(0, 3);
            @(negedge clk); #1;
            check(mem_req && mem_addr == la, "R4 fetch addr", mem_addr, la);
            for (int k = 0; k < lat; k++) begin
                @(negedge clk); #1;
                check(mem_req && cpu_stall && mem_addr == la, "R4 fetch held", mem_addr, la);
            end
            mem_valid = 1'b1;
            mem_line  = mk_line(la);
            @(posedge clk); #1;
            mem_valid = 1'b0;
            mem_line  = '0;
            m_vld[idx][v] = 1'b1;
            m_tag[idx][v] = tg;
            m_lru[idx]    = ~v;
            @(negedge clk); #1;
            check(cpu_hit && !cpu_stall, "R5 retry hit", 32'(cpu_hit), 32'd1);
            check(cpu_data == expd, "R5 filled data", cpu_data, expd);
            @(posedge clk);
        end
    endtask

    function automatic logic [31:0] mk_addr(input logic [22:0] t, input logic [3:0] i, input logic [4:0] o);
        return {t, i, o};
    endfunction

    initial begin
        for (int s = 0; s < 16; s++) begin
            m_lru[s] = 1'b0;
            for (int w = 0; w < 2; w++) begin
                m_vld[s][w] = 1'b0;
                m_tag[s][w] = '0;
            end
        end
        void'($urandom(32'd7261));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R8 reset state
        check(!cpu_hit && !cpu_stall && !mem_req, "R8 reset outputs",
              {29'd0, cpu_hit, cpu_stall, mem_req}, 32'd0);
        // R8, R1: first access misses; byte bits ignored
        access(mk_addr(23'h000050, 4'd1, 5'h00));
        access(mk_addr(23'h000050, 4'd1, 5'h0B));
        access(mk_addr(23'h000050, 4'd1, 5'h1F));
        // R6: second tag in same set coexists
        access(mk_addr(23'h0002FE, 4'd1, 5'h04));
        access(mk_addr(23'h000050, 4'd1, 5'h10));
        access(mk_addr(23'h0002FE, 4'd1, 5'h18));
        // R7: touch first tag, third tag must evict second
        access(mk_addr(23'h000050, 4'd1, 5'h00));
        access(mk_addr(23'h002450, 4'd1, 5'h08));
        access(mk_addr(23'h000050, 4'd1, 5'h0C));
        access(mk_addr(23'h0002FE, 4'd1, 5'h00));
        // R1: same tag, other set is separate
        access(mk_addr(23'h000050, 4'd2, 5'h00));
        access(mk_addr(23'h7FFFFF, 4'd15, 5'h1C));
        access(mk_addr(23'h7FFFFF, 4'd15, 5'h1C));
        // random traffic on a small pool to force conflicts
        for (int n = 0; n < 600; n++) begin
            logic [22:0] t;
            logic [3:0]  i;
            t = 23'($urandom_range(0, 3)) * 23'h01_1111;
            i = 4'($urandom_range(0, 2)) * 4'd5;
            access(mk_addr(t, i, 5'($urandom_range(0, 31))));
        end
        @(negedge clk);
        cpu_req = 1'b0;
        #1;
        check(!cpu_stall && !cpu_hit, "R2 idle", 32'(cpu_stall), 32'd0);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule